// File: doc/BRIEF.md
# Bit-Sliced Four-Function ALU

This block is an 8-bit combinational arithmetic logic unit. It is built from one bit slice that is repeated once per bit of the word. Each slice has a small logic unit and a full adder. It also has its own 2-to-4 decoder, which turns the shared 2-bit function code into four one-hot enables. Each enable gates one candidate result, and the gated results are ORed onto the slice output.

The selectable functions are bitwise AND, bitwise OR, inversion of operand A, and binary addition with carry-in. Carry travels from the least significant slice to the most significant one. The carry out of the top slice is presented only while addition is selected and reads 0 for every logical function.

The block has no clock and no state. A result follows its operands and function code combinationally, so a surrounding datapath can register it wherever its timing allows.

Top module: `bsa_alu`

## Requirements
- R1: Function code 2'b00 gives o_o = a_i AND b_i, bit by bit.
- R2: Function code 2'b01 gives o_o = a_i OR b_i, bit by bit.
- R3: Function code 2'b10 gives o_o = NOT a_i. The values of b_i and cin_i have no effect on o_o or cout_o.
- R4: Function code 2'b11 gives {cout_o, o_o} = a_i + b_i + cin_i, an unsigned sum 9 bits wide.
- R5: During addition a carry travels through every slice. For example, 8'hFF + 8'h00 with cin_i = 1 gives o_o = 8'h00 and cout_o = 1.
- R6: For function codes 2'b00, 2'b01 and 2'b10, cout_o is 0 and cin_i has no effect on o_o, even when the operands would produce a carry in addition.
- R7: The unit holds no state. o_o and cout_o reflect a change of the inputs within the same clock period, with no register delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| fn_i | input | 2 | Function code: 00 AND, 01 OR, 10 NOT A, 11 add |
| cin_i | input | 1 | Carry into the least significant slice |
| o_o | output | 8 | Result word |
| cout_o | output | 1 | Carry out of the most significant slice, used for addition only |

## Verification
In every slice the adder and the logic unit evaluate the same operands at the same time. The risk is that the adder's sum or its rippling carry leaks into a logical result or into cout_o.

The bench provokes this by selecting AND, OR and NOT with operands that would carry through all eight slices in addition: all-ones operands with a carry-in of 1. It then requires the logical result with cout_o at 0. It also requires a full-width ripple to appear on the output only when the add code is selected.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  localparam int unsigned FN_W     = 2;
  localparam int unsigned FN_COUNT = 1 << FN_W;

  // Function codes; each value doubles as the index of its one-hot enable.
  typedef enum logic [FN_W-1:0] {
    FN_AND = 2'b00,
    FN_OR  = 2'b01,
    FN_INV = 2'b10,
    FN_ADD = 2'b11
  } fn_e;

  typedef logic [FN_COUNT-1:0] fn_en_t;

endpackage

// File: rtl/bsa_half_add.sv
module bsa_half_add (
  input  logic x_i,
  input  logic y_i,
  output logic s_o,
  output logic c_o
);

  assign s_o = x_i ^ y_i;
  assign c_o = x_i & y_i;

endmodule

// File: rtl/bsa_full_add.sv
module bsa_full_add (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  logic part_sum;
  logic part_c0;
  logic part_c1;

  // The first half adder combines the two operand bits.
  bsa_half_add i_ha_ops (
    .x_i (x_i),
    .y_i (y_i),
    .s_o (part_sum),
    .c_o (part_c0)
  );

  // The second half adder folds in the incoming carry.
  bsa_half_add i_ha_cin (
    .x_i (part_sum),
    .y_i (c_i),
    .s_o (s_o),
    .c_o (part_c1)
  );

  // At most one of the two partial carries can be set.
  assign c_o = part_c0 | part_c1;

endmodule

// File: rtl/bsa_fn_decode.sv
module bsa_fn_decode
  import bsa_pkg::*;
(
  input  logic [FN_W-1:0] fn_i,
  output fn_en_t          en_o
);

  for (genvar k = 0; k < FN_COUNT; k++) begin : g_line
    assign en_o[k] = (fn_i == FN_W'(k));
  end

endmodule

// File: rtl/bsa_slice.sv
module bsa_slice
  import bsa_pkg::*;
(
  input  logic [FN_W-1:0] fn_i,
  input  logic            a_i,
  input  logic            b_i,
  input  logic            c_i,
  output logic            o_o,
  output logic            c_o
);

  fn_en_t en;
  fn_en_t cand;
  logic   sum;

  // Local decoder: one enable line per function.
  bsa_fn_decode i_dec (
    .fn_i (fn_i),
    .en_o (en)
  );

  bsa_full_add i_fa (
    .x_i (a_i),
    .y_i (b_i),
    .c_i (c_i),
    .s_o (sum),
    .c_o (c_o)
  );

  // Candidate results, each placed at the index of its function code.
  always_comb begin
    cand         = '0;
    cand[FN_AND] = a_i & b_i;
    cand[FN_OR]  = a_i | b_i;
    cand[FN_INV] = ~a_i;
    cand[FN_ADD] = sum;
  end

  // Gate each candidate with its enable, then OR the gated results together.
  assign o_o = |(cand & en);

endmodule

// File: rtl/bsa_alu.sv
module bsa_alu
  import bsa_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [FN_W-1:0]  fn_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] o_o,
  output logic             cout_o
);

  localparam int unsigned CHAIN = WIDTH + 1;

  logic [CHAIN-1:0] carry;
  logic             add_sel;

  assign carry[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    bsa_slice i_slice (
      .fn_i (fn_i),
      .a_i  (a_i[i]),
      .b_i  (b_i[i]),
      .c_i  (carry[i]),
      .o_o  (o_o[i]),
      .c_o  (carry[i+1])
    );
  end

  // The carry out of the top slice leaves the block only for addition.
  assign add_sel = (fn_i == FN_ADD);
  assign cout_o  = carry[WIDTH] & add_sel;

endmodule

// File: rtl/bsa_alu_chk.sv
module bsa_alu_chk
  import bsa_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [FN_W-1:0]  fn_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] o_o,
  input logic             cout_o
);

  localparam int unsigned SW = WIDTH + 1;

  logic [SW-1:0] ref_sum;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + SW'(cin_i);

  always_comb begin
    if (!$isunknown({a_i, b_i, fn_i, cin_i})) begin
      if (fn_i == FN_AND) begin
        a_r1_and: assert (o_o == (a_i & b_i)) else $error("and result wrong");
      end
      if (fn_i == FN_OR) begin
        a_r2_or: assert (o_o == (a_i | b_i)) else $error("or result wrong");
      end
      if (fn_i == FN_INV) begin
        a_r3_inv: assert (o_o == ~a_i) else $error("inversion result wrong");
      end
      if (fn_i == FN_ADD) begin
        a_r4_add: assert ({cout_o, o_o} == ref_sum) else $error("sum wrong");
      end
      if (fn_i != FN_ADD) begin
        a_r6_no_carry: assert (!cout_o) else $error("carry out during logic op");
      end
    end
  end

endmodule

bind bsa_alu bsa_alu_chk #(.WIDTH(WIDTH)) i_bsa_alu_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .fn_i   (fn_i),
  .cin_i  (cin_i),
  .o_o    (o_o),
  .cout_o (cout_o)
);

// File: tb/test_bsa_alu.sv
module test_bsa_alu;

  localparam int unsigned W = 8;

  logic         clk;
  logic [W-1:0] a, b, o;
  logic [1:0]   fn;
  logic         cin, cout;

  int n_chk  = 0;
  int n_fail = 0;

  bsa_alu #(.WIDTH(W)) i_bsa_alu (
    .a_i    (a),
    .b_i    (b),
    .fn_i   (fn),
    .cin_i  (cin),
    .o_o    (o),
    .cout_o (cout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [1:0]   fn;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         cin;
    logic [W-1:0] o;
    logic         co;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 8'hF0, 8'h3C, 1'b1, 8'h30, 1'b0, 4'd1}, // R1
    '{2'b00, 8'hFF, 8'hFF, 1'b1, 8'hFF, 1'b0, 4'd6}, // R6 carry-heavy AND
    '{2'b01, 8'hF0, 8'h0F, 1'b0, 8'hFF, 1'b0, 4'd2}, // R2
    '{2'b01, 8'hA5, 8'h00, 1'b1, 8'hA5, 1'b0, 4'd2}, // R2
    '{2'b10, 8'hA5, 8'hFF, 1'b1, 8'h5A, 1'b0, 4'd3}, // R3 b,cin ignored
    '{2'b10, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b0, 4'd3}, // R3
    '{2'b11, 8'h12, 8'h34, 1'b0, 8'h46, 1'b0, 4'd4}, // R4
    '{2'b11, 8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, 4'd5}, // R5
    '{2'b11, 8'hFF, 8'h00, 1'b1, 8'h00, 1'b1, 4'd5}, // R5 full ripple
    '{2'b11, 8'hFF, 8'hFF, 1'b1, 8'hFF, 1'b1, 4'd4}, // R4
    '{2'b11, 8'h80, 8'h80, 1'b0, 8'h00, 1'b1, 4'd4}, // R4
    '{2'b11, 8'h00, 8'h00, 1'b1, 8'h01, 1'b0, 4'd4}, // R4
    '{2'b11, 8'h0F, 8'hF0, 1'b0, 8'hFF, 1'b0, 4'd4}  // R4
  };

  function automatic logic [W:0] model(logic [1:0] f, logic [W-1:0] x,
                                       logic [W-1:0] y, logic c);
    case (f)
      2'b00:   model = {1'b0, x & y};
      2'b01:   model = {1'b0, x | y};
      2'b10:   model = {1'b0, ~x};
      default: model = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    endcase
  endfunction

  task automatic chk(string tag, logic [W-1:0] oe, logic coe);
    n_chk++;
    if (o !== oe || cout !== coe) begin
      n_fail++;
      $display("FAIL %s: got o=%h co=%b, want o=%h co=%b", tag, o, cout, oe, coe);
    end
  endtask

  task automatic apply(logic [1:0] f, logic [W-1:0] x, logic [W-1:0] y, logic c);
    @(posedge clk);
    fn = f; a = x; b = y; cin = c;
    @(negedge clk);
  endtask

  initial begin
    logic [W:0] e;
    fn = 2'b00; a = '0; b = '0; cin = 1'b0;
    @(negedge clk);
    chk("R1 idle", 8'h00, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].fn, VECS[i].a, VECS[i].b, VECS[i].cin);
      chk($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].o, VECS[i].co);
    end

    // R6: every logical code with an operand pair that ripples fully in add
    for (int f = 0; f < 3; f++) begin
      apply(2'(f), 8'hFF, 8'hFF, 1'b1);
      e = model(2'(f), 8'hFF, 8'hFF, 1'b1);
      chk("R6 logic no carry", e[W-1:0], 1'b0);
      apply(2'(f), 8'h5A, 8'hC3, 1'b0);
      e = model(2'(f), 8'h5A, 8'hC3, 1'b1);
      chk("R6 cin no effect", e[W-1:0], 1'b0);
    end

    // R3: b and cin toggled while NOT is selected leave the result alone
    apply(2'b10, 8'h3C, 8'h00, 1'b0);
    b = 8'hFF; cin = 1'b1; #1;
    chk("R3 b/cin ignored", 8'hC3, 1'b0);

    // R7: an input change shows one time unit later, before any clock edge
    @(posedge clk);
    fn = 2'b11; a = 8'h7F; b = 8'h01; cin = 1'b0; #1;
    chk("R7 comb add", 8'h80, 1'b0);
    fn = 2'b00; #1;
    chk("R7 comb and", 8'h01, 1'b0);

    // Random operands over all codes against the bench model (R1 R2 R3 R4)
    for (int i = 0; i < 400; i++) begin
      logic [1:0]   rf = 2'($urandom);
      logic [W-1:0] ra = W'($urandom);
      logic [W-1:0] rb = W'($urandom);
      logic         rc = 1'($urandom);
      apply(rf, ra, rb, rc);
      e = model(rf, ra, rb, rc);
      chk($sformatf("R%0d random", rf == 2'b00 ? 1 : rf == 2'b01 ? 2 :
                                   rf == 2'b10 ? 3 : 4), e[W-1:0], e[W]);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule